// File: doc/BRIEF.md
# Continuous SAR ADC Sequencer

This block is the digital half of an 8-bit successive-approximation converter. Software writes a control register that holds a channel number and an enable bit. While enabled, the sequencer converts the selected input over and over, with no gap between conversions. Each conversion first closes the sample switch for a loading phase. It then opens the switch and runs a binary search from the most significant bit down to the least, using the trial code it drives to the DAC and the comparator bit it reads back. The converter clock is one pulse every `DIV` CPU clocks.

A finished conversion copies the result into the data register and sets a done flag. No interrupt is raised. Any control write clears the done flag and discards the conversion in progress. A write with enable set restarts at the sampling phase. A write with enable clear parks the sequencer in idle and leaves the last result in place.

The state machine has three states:
- `ST_IDLE`: the switch is open and the DAC code is zero.
- `ST_LOAD`: the switch is closed for `SAMPLE_CLKS` converter clocks.
- `ST_CONV`: one SAR step per converter clock.

Its transitions are:
- start (enable write) → `ST_LOAD` from any state.
- stop (disable write) → `ST_IDLE` from any state.
- load done (last sample tick) `ST_LOAD` → `ST_CONV`.
- step (tick with bits left) `ST_CONV` → `ST_CONV`.
- finish (tick on the LSB) `ST_CONV` → `ST_LOAD`, which raises the done pulse.

Top module: `sar_adc_seq`

## Requirements
- R1: A converter tick occurs every `DIV` (4) CPU clocks, counted from the latest control write. A conversion started by a write completes exactly 48 CPU clocks after that write's clock edge (4 load ticks + 8 SAR ticks).
- R2: `samp_close` is high for the first 16 CPU clocks of each conversion and low for the remaining 32.
- R3: The SAR resolves MSB first. A trial bit is kept when `comp_in` is 1 (input ≥ code). The final result therefore equals the sampled input value.
- R4: While enabled, the next conversion begins in the cycle right after a completion, with `samp_close` high again, and completes 48 cycles later.
- R5: On completion the done flag (`ctrl_rdata[5]`) is set. It stays set through later completions until a control write.
- R6: `data_rdata` changes only at a completion. Partial SAR values never appear on it.
- R7: A control write with enable bit `ctrl_wdata[4]`=1 clears the done flag in the next cycle. It also aborts the running conversion, so the next completion is 48 cycles after that write.
- R8: A control write with `ctrl_wdata[4]`=0 clears the done flag and idles the sequencer. After that write, `samp_close`=0, `dac_code`=0, no done occurs and `data_rdata` holds its value.
- R9: The channel field `ctrl_wdata[3:0]` is stored in `ctrl_rdata[3:0]` and drives `chan_sel`. The enable bit reads back at `ctrl_rdata[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | {enable, channel[3:0]} |
| ctrl_rdata | output | 6 | {done, enable, channel[3:0]} |
| data_rdata | output | 8 | Last completed result |
| comp_in | input | 1 | Comparator: 1 when input ≥ DAC code |
| samp_close | output | 1 | Sample switch closed |
| dac_code | output | 8 | Trial code to the DAC |
| chan_sel | output | 4 | Analog mux select |

## Verification
The bench builds the block with its default parameters: a divide-by-4 converter clock, four loading ticks, 8 result bits and 4 channel bits. Each conversion is then only 48 cycles long. This makes it affordable to convert every one of the 256 input codes, rotating across all 16 channels. Back-to-back conversion, abort-and-restart and disable are then exercised on top of that sweep.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST) && !restart;

    generate
        if (DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate
endmodule

// File: rtl/sar_core_fsm.sv
module sar_core_fsm
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SAMPLE_CLKS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic                stop,
    input  logic                comp_in,
    output logic                samp_close,
    output logic [RES_BITS-1:0] dac_code,
    output logic                done_pulse,
    output logic [RES_BITS-1:0] result
);
    localparam int BI_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam int PH_W = $clog2(SAMPLE_CLKS + 1);
    localparam logic [PH_W-1:0]     PH_LAST = PH_W'(SAMPLE_CLKS - 1);
    localparam logic [BI_W-1:0]     BI_TOP  = BI_W'(RES_BITS - 1);
    localparam logic [RES_BITS-1:0] MSB_ONE = RES_BITS'(1) << (RES_BITS - 1);

    seq_state_e          st_q, st_d;
    logic [PH_W-1:0]     ph_q, ph_d;
    logic [BI_W-1:0]     bi_q, bi_d;
    logic [RES_BITS-1:0] sar_q, sar_d;
    logic [RES_BITS-1:0] cur_bit, next_bit, kept;

    assign cur_bit  = RES_BITS'(1) << bi_q;
    assign next_bit = cur_bit >> 1;
    assign kept     = comp_in ? sar_q : (sar_q & ~cur_bit);

    // next-state logic
    always_comb begin
        st_d       = st_q;
        ph_d       = ph_q;
        bi_d       = bi_q;
        sar_d      = sar_q;
        done_pulse = 1'b0;
        if (stop) begin
            st_d  = ST_IDLE;
            sar_d = '0;
        end else if (start) begin
            st_d  = ST_LOAD;
            ph_d  = '0;
            sar_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_LOAD: begin
                    if (tick) begin
                        if (ph_q == PH_LAST) begin
                            st_d  = ST_CONV;
                            bi_d  = BI_TOP;
                            sar_d = MSB_ONE;
                        end else begin
                            ph_d = ph_q + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (bi_q == '0) begin
                            st_d       = ST_LOAD;
                            ph_d       = '0;
                            sar_d      = '0;
                            done_pulse = 1'b1;
                        end else begin
                            bi_d  = bi_q - 1'b1;
                            sar_d = kept | next_bit;
                        end
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ph_q  <= '0;
            bi_q  <= '0;
            sar_q <= '0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            bi_q  <= bi_d;
            sar_q <= sar_d;
        end
    end

    // outputs
    always_comb begin
        samp_close = (st_q == ST_LOAD);
        dac_code   = (st_q == ST_CONV) ? sar_q : '0;
        result     = kept;
    end

    AST_TRIAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV) |-> ((sar_q & cur_bit) != '0)); // R3
    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R4
    AST_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> samp_close); // R4
endmodule

// File: rtl/sar_ctrl_regs.sv
module sar_ctrl_regs #(
    parameter int RES_BITS = 8,
    parameter int CH_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CH_W:0]       ctrl_wdata,
    input  logic                done_pulse,
    input  logic [RES_BITS-1:0] result,
    output logic                en_q,
    output logic [CH_W-1:0]     chan_q,
    output logic                done_q,
    output logic [RES_BITS-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            chan_q <= '0;
            done_q <= 1'b0;
            data_q <= '0;
        end else if (ctrl_wr) begin
            en_q   <= ctrl_wdata[CH_W];
            chan_q <= ctrl_wdata[CH_W-1:0];
            done_q <= 1'b0;
        end else if (done_pulse) begin
            done_q <= 1'b1;
            data_q <= result;
        end
    end

    AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !done_q); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |=> $stable(data_q)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ctrl_wr) |=> done_q); // R5
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
    parameter int DIV         = 4,
    parameter int SAMPLE_CLKS = 4,
    parameter int RES_BITS    = 8,
    parameter int CH_W        = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CH_W:0]       ctrl_wdata,
    output logic [CH_W+1:0]     ctrl_rdata,
    output logic [RES_BITS-1:0] data_rdata,
    input  logic                comp_in,
    output logic                samp_close,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_W-1:0]     chan_sel
);
    logic                tick;
    logic                start, stop;
    logic                done_pulse;
    logic [RES_BITS-1:0] result;
    logic                en_q, done_q;
    logic [CH_W-1:0]     chan_q;

    assign start = ctrl_wr &&  ctrl_wdata[CH_W];
    assign stop  = ctrl_wr && !ctrl_wdata[CH_W];

    sar_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .tick    (tick)
    );

    sar_core_fsm #(.RES_BITS(RES_BITS), .SAMPLE_CLKS(SAMPLE_CLKS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .stop       (stop),
        .comp_in    (comp_in),
        .samp_close (samp_close),
        .dac_code   (dac_code),
        .done_pulse (done_pulse),
        .result     (result)
    );

    sar_ctrl_regs #(.RES_BITS(RES_BITS), .CH_W(CH_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .done_pulse (done_pulse),
        .result     (result),
        .en_q       (en_q),
        .chan_q     (chan_q),
        .done_q     (done_q),
        .data_q     (data_q_w)
    );

    logic [RES_BITS-1:0] data_q_w;

    assign ctrl_rdata = {done_q, en_q, chan_q};
    assign data_rdata = data_q_w;
    assign chan_sel   = chan_q;

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_wr) |-> !done_pulse); // R8
endmodule

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [5:0] ctrl_rdata;
    logic [7:0] data_rdata;
    logic       comp_in;
    logic       samp_close;
    logic [7:0] dac_code;
    logic [3:0] chan_sel;

    int total = 0;
    int bad = 0;

    logic [7:0] ain [16];
    logic [7:0] held = '0;

    always #10 clk = ~clk;

    // behavioural sample capacitor and comparator
    always @(posedge clk) if (samp_close) held <= ain[chan_sel];
    assign comp_in = (held >= dac_code);

    sar_adc_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .data_rdata (data_rdata),
        .comp_in    (comp_in),
        .samp_close (samp_close),
        .dac_code   (dac_code),
        .chan_sel   (chan_sel)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // leaves the caller half a cycle after the write edge
    task automatic wr_ctrl(input logic en, input logic [3:0] ch);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = {en, ch};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        for (int i = 0; i < 16; i++) ain[i] = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("reset ctrl R5", ctrl_rdata, 0);
        chk("reset data R6", data_rdata, 0);
        chk("reset samp R2", samp_close, 0);
        chk("reset dac R8", dac_code, 0);

        // full code sweep across all channels, each started by a write
        prev = 8'd0;
        for (int v = 0; v < 256; v++) begin
            ain[v % 16] = 8'(v);
            wr_ctrl(1'b1, 4'(v % 16));
            chk("R7 done cleared", ctrl_rdata[5], 0);
            chk("R9 chan readback", ctrl_rdata[4:0], 16 + (v % 16));
            chk("R9 chan_sel", chan_sel, v % 16);
            chk("R2 samp start", samp_close, 1);
            wait_cyc(15);
            chk("R2 samp end load", samp_close, 1);
            wait_cyc(1);
            chk("R2 samp open", samp_close, 0);
            wait_cyc(31);
            chk("R1 not yet done", ctrl_rdata[5], 0);
            chk("R6 data held", data_rdata, prev);
            wait_cyc(1);
            chk("R1 done at 48", ctrl_rdata[5], 1);
            chk("R3 result", data_rdata, v);
            prev = 8'(v);
        end

        // back-to-back conversion without any write
        ain[15] = 8'd77;
        chk("R4 reload", samp_close, 1);
        wait_cyc(47);
        chk("R6 hold mid", data_rdata, 255);
        chk("R5 sticky", ctrl_rdata[5], 1);
        wait_cyc(1);
        chk("R4 next result", data_rdata, 77);
        chk("R5 still set", ctrl_rdata[5], 1);

        // abort mid-conversion
        ain[3] = 8'd200;
        wr_ctrl(1'b1, 4'd3);
        wait_cyc(20);
        ain[3] = 8'd50;
        wr_ctrl(1'b1, 4'd3);
        chk("R7 abort clears done", ctrl_rdata[5], 0);
        wait_cyc(27);
        chk("R7 old conv discarded", ctrl_rdata[5], 0);
        chk("R7 data kept", data_rdata, 77);
        wait_cyc(20);
        chk("R7 not early", ctrl_rdata[5], 0);
        wait_cyc(1);
        chk("R7 restart done", ctrl_rdata[5], 1);
        chk("R7 restart result", data_rdata, 50);

        // disable write mid-conversion
        ain[5] = 8'd9;
        wr_ctrl(1'b1, 4'd5);
        wait_cyc(30);
        wr_ctrl(1'b0, 4'd5);
        chk("R8 ctrl readback", ctrl_rdata, 5);
        begin
            int errs = 0;
            for (int k = 0; k < 200; k++) begin
                if (samp_close !== 1'b0 || dac_code !== 8'd0 ||
                    ctrl_rdata[5] !== 1'b0 || data_rdata !== 8'd50) errs++;
                wait_cyc(1);
            end
            chk("R8 idle quiet", errs, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule